// File: doc/BRIEF.md
# Arithmetic Bidirectional Barrel Shifter

This block shifts a fixed-point data word by a distance given on an input port, in one pass and with no iteration. A left shift moves bits toward the MSB and fills the freed low bits with zeros, so the sign of a signed word can be lost. A right shift is arithmetic: the freed high bits are filled with copies of the original sign bit, which makes it a divide by a power of two that rounds toward minus infinity. Unsigned words are filled with zeros on a right shift.

A build-time parameter fixes the direction to left only or right only, or takes it from a direction pin on every cycle. The distance port width is a parameter and defaults to the data width. Any distance at or above the word width saturates the shift. A second parameter picks between a purely combinational result and a registered result with one cycle of latency. In the registered form the register has a clock enable and an asynchronous clear.

Top module: `arithShifter`

## Requirements
- R1: With the runtime direction mode, `direction` = 0 selects a left shift (toward the MSB) and `direction` = 1 selects a right shift (toward the LSB).
- R2: A right shift of signed data fills the vacated upper bits with copies of bit DATA_W-1 of the input word.
- R3: A left shift fills the vacated lower bits with zeros and does not correct the sign, so a positive word may become negative and a negative word may become zero.
- R4: A distance equal to or greater than DATA_W gives all zeros for a left shift and DATA_W copies of the sign bit for a right shift.
- R5: A distance of zero passes the input word through unchanged in either direction.
- R6: With the pipeline option on, `result` takes the shifted value at the first rising clock edge where `enable` is 1, which gives one cycle of latency.
- R7: With the pipeline option on, `enable` = 0 at a rising edge leaves `result` unchanged, whatever the data, distance and direction.
- R8: With the pipeline option on, `clrAsync` = 1 forces `result` to zero at once, without waiting for a clock edge, and keeps it there even when `enable` is 1.
- R9: With a fixed direction mode, the `direction` pin has no effect on `result`.
- R10: With the pipeline option off, `result` follows the inputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| clrAsync | input | 1 | Asynchronous clear of the result register, active high |
| enable | input | 1 | Clock enable of the result register |
| direction | input | 1 | 0 = shift left, 1 = shift right (runtime mode only) |
| dataIn | input | DATA_W | Word to shift |
| distance | input | DIST_W | Shift distance, unsigned |
| result | output | DATA_W | Shifted word |

## Verification
A capture by the result register and the asynchronous clear can fall in the same cycle. To provoke this, the bench drives `enable` high with a fresh, nonzero word and raises `clrAsync` in the middle of the cycle. It checks that `result` is zero before the next edge, that it stays zero across that edge while the clear is held, and that the held word appears one edge after the clear is released. The saturating distance and the sign fill of right shifts are also tested together, by shifting negative words by exactly the width and by the largest distance.

// File: rtl/shiftPkg.sv
package shiftPkg;
  // Build-time choice of shift direction
  typedef enum logic [1:0] {
    DIR_LEFT  = 2'd0,
    DIR_RIGHT = 2'd1,
    DIR_PIN   = 2'd2
  } shiftDir_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic shiftRight;
    logic capture;
  } shiftCtl_t;
endpackage

// File: rtl/shiftCtl.sv
module shiftCtl #(
  parameter shiftPkg::shiftDir_e DIR_MODE = shiftPkg::DIR_PIN
) (
  input  logic                direction,
  input  logic                enable,
  output shiftPkg::shiftCtl_t ctl
);
  logic wantRight;

  generate
    if (DIR_MODE == shiftPkg::DIR_LEFT) begin : g_left
      assign wantRight = 1'b0;
    end else if (DIR_MODE == shiftPkg::DIR_RIGHT) begin : g_right
      assign wantRight = 1'b1;
    end else begin : g_pin
      assign wantRight = direction;  // 0 = toward MSB, 1 = toward LSB
    end
  endgenerate

  assign ctl.shiftRight = wantRight;
  assign ctl.capture    = enable;
endmodule

// File: rtl/shiftCore.sv
module shiftCore #(
  parameter int DATA_W      = 16,
  parameter int DIST_W      = DATA_W,
  parameter bit SIGNED_DATA = 1'b1,
  parameter bit PIPELINE    = 1'b1
) (
  input  logic                clk,
  input  logic                clrAsync,
  input  shiftPkg::shiftCtl_t ctl,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DIST_W-1:0]   distance,
  output logic [DATA_W-1:0]   result
);
  localparam int STAGES = $clog2(DATA_W);
  localparam int USED   = (DIST_W < STAGES) ? DIST_W : STAGES;
  localparam int WIDE   = DIST_W + 32;

  logic                fillBit;
  logic                overflow;
  logic [DATA_W-1:0]   stage [USED+1];
  logic [DATA_W-1:0]   shifted;

  assign fillBit  = SIGNED_DATA & dataIn[DATA_W-1];
  assign overflow = WIDE'(distance) >= WIDE'(DATA_W);
  assign stage[0] = dataIn;

  // One stage per distance bit, each moving by a power of two
  generate
    for (genvar k = 0; k < USED; k++) begin : g_stage
      localparam int SH = 1 << k;
      assign stage[k+1] = !distance[k] ? stage[k] :
                          (ctl.shiftRight ? {{SH{fillBit}}, stage[k][DATA_W-1:SH]}
                                          : {stage[k][DATA_W-1-SH:0], {SH{1'b0}}});
    end
  endgenerate

  assign shifted = overflow ? (ctl.shiftRight ? {DATA_W{fillBit}} : '0) : stage[USED];

  generate
    if (PIPELINE) begin : g_reg
      always_ff @(posedge clk or posedge clrAsync) begin
        if (clrAsync)         result <= '0;
        else if (ctl.capture) result <= shifted;
      end

      AST_CAPTURE: assert property (@(posedge clk) disable iff (clrAsync)
        ctl.capture |=> result == $past(shifted));  // R6
      AST_HOLD: assert property (@(posedge clk) disable iff (clrAsync)
        !ctl.capture |=> $stable(result));  // R7
    end else begin : g_comb
      assign result = shifted;
    end
  endgenerate

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (clrAsync)
    (ctl.shiftRight && SIGNED_DATA) |-> shifted[DATA_W-1] == dataIn[DATA_W-1]);  // R2
  AST_LEFT_ZERO_LSB: assert property (@(posedge clk) disable iff (clrAsync)
    (!ctl.shiftRight && distance != '0) |-> !shifted[0]);  // R3
  AST_LEFT_SATURATE: assert property (@(posedge clk) disable iff (clrAsync)
    (!ctl.shiftRight && WIDE'(distance) >= WIDE'(DATA_W)) |-> shifted == '0);  // R4
  AST_ZERO_DIST: assert property (@(posedge clk) disable iff (clrAsync)
    (distance == '0) |-> shifted == dataIn);  // R5
endmodule

// File: rtl/arithShifter.sv
module arithShifter #(
  parameter int                  DATA_W      = 16,
  parameter int                  DIST_W      = DATA_W,
  parameter bit                  SIGNED_DATA = 1'b1,
  parameter bit                  PIPELINE    = 1'b1,
  parameter shiftPkg::shiftDir_e DIR_MODE    = shiftPkg::DIR_PIN
) (
  input  logic              clk,
  input  logic              clrAsync,
  input  logic              enable,
  input  logic              direction,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DIST_W-1:0] distance,
  output logic [DATA_W-1:0] result
);
  shiftPkg::shiftCtl_t ctl;

  shiftCtl #(
    .DIR_MODE(DIR_MODE)
  ) u_ctl (
    .direction(direction),
    .enable   (enable),
    .ctl      (ctl)
  );

  shiftCore #(
    .DATA_W     (DATA_W),
    .DIST_W     (DIST_W),
    .SIGNED_DATA(SIGNED_DATA),
    .PIPELINE   (PIPELINE)
  ) u_core (
    .clk     (clk),
    .clrAsync(clrAsync),
    .ctl     (ctl),
    .dataIn  (dataIn),
    .distance(distance),
    .result  (result)
  );
endmodule

// File: tb/test_arithShifter.sv
module test_arithShifter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] d;
    logic [W-1:0] s;
    logic         r;
    logic [W-1:0] e;   // expected, runtime direction
    logic [W-1:0] er;  // expected, right-only instance
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 16'd4,      1'b0, 16'h2340, 16'h0123}, // R1 R3 left
    '{16'h1234, 16'd4,      1'b1, 16'h0123, 16'h0123}, // R1 right positive
    '{16'h8001, 16'd1,      1'b1, 16'hC000, 16'hC000}, // R2 sign fill
    '{16'hF0F0, 16'd4,      1'b1, 16'hFF0F, 16'hFF0F}, // R2
    '{16'h4001, 16'd1,      1'b0, 16'h8002, 16'h2000}, // R3 positive turns negative
    '{16'hC000, 16'd2,      1'b0, 16'h0000, 16'hF000}, // R3 negative turns zero
    '{16'hABCD, 16'd0,      1'b0, 16'hABCD, 16'hABCD}, // R5
    '{16'hABCD, 16'd0,      1'b1, 16'hABCD, 16'hABCD}, // R5
    '{16'h8000, 16'd16,     1'b1, 16'hFFFF, 16'hFFFF}, // R4 right, negative
    '{16'h7FFF, 16'd16,     1'b1, 16'h0000, 16'h0000}, // R4 right, positive
    '{16'hFFFF, 16'd16,     1'b0, 16'h0000, 16'hFFFF}, // R4 left
    '{16'h8000, 16'd15,     1'b1, 16'hFFFF, 16'hFFFF}, // R2 largest in-range
    '{16'h0001, 16'd15,     1'b0, 16'h8000, 16'h0000}, // R3 largest in-range
    '{16'h8000, 16'hFFFF,   1'b1, 16'hFFFF, 16'hFFFF}, // R4 largest distance
    '{16'h1234, 16'd8,      1'b1, 16'h0012, 16'h0012}, // R1
    '{16'h00FF, 16'd7,      1'b0, 16'h7F80, 16'h0001}  // R3
  };

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         enable = 1'b0;
  logic         direction = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] distance = '0;
  logic [W-1:0] result;
  logic [W-1:0] resultFixed;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arithShifter #(.DATA_W(W)) i_arithShifter (
    .clk(clk), .clrAsync(clr), .enable(enable), .direction(direction),
    .dataIn(dataIn), .distance(distance), .result(result)
  );

  arithShifter #(.DATA_W(W), .PIPELINE(1'b0), .DIR_MODE(shiftPkg::DIR_RIGHT)) i_arithShifter_fixed (
    .clk(clk), .clrAsync(clr), .enable(enable), .direction(direction),
    .dataIn(dataIn), .distance(distance), .result(resultFixed)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    #(CLK_PERIOD*2 + 1);
    check("R8 reset value", result, '0);
    @(negedge clk);
    clr = 1'b0;
    enable = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dataIn    = VECS[i].d;
      distance  = VECS[i].s;
      direction = VECS[i].r;
      #1;
      check("R10 R9 fixed right, same cycle", resultFixed, VECS[i].er);
      @(negedge clk);
      check("R1..table pipelined", result, VECS[i].e);
    end

    // R6: one cycle latency
    @(negedge clk);
    dataIn = 16'h0F00; distance = 16'd4; direction = 1'b0;
    #(CLK_PERIOD/2 - 1);
    check("R6 before edge", result, VECS[NV-1].e);
    @(negedge clk);
    check("R6 after edge", result, 16'hF000);

    // R7: enable low holds
    held = result;
    enable = 1'b0;
    dataIn = 16'h5555; distance = 16'd1; direction = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 hold", result, held);
    enable = 1'b1;
    @(negedge clk);
    check("R7 release", result, 16'h2AAA);

    // R8: clear collides with capture
    dataIn = 16'h8421; distance = 16'd0;
    #(CLK_PERIOD/4);
    clr = 1'b1;
    #1;
    check("R8 clear before edge", result, '0);
    @(negedge clk);
    check("R8 clear across enabled edge", result, '0);
    clr = 1'b0;
    @(negedge clk);
    check("R8 capture after release", result, 16'h8421);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule